// File: doc/BRIEF.md
# Measurement Threshold Monitor

This block watches a set of measurement channels and flags any value that leaves its allowed window. Channel 0 carries a signed temperature reading, channel 1 an unsigned supply-voltage reading, and channels 2 and up carry unsigned receive-power readings, one per receiver. Each channel has a high and a low alarm threshold and a high and a low warning threshold. A new reading arrives with a one-cycle update strobe, and the four comparisons for that channel are evaluated only on that strobe. Each receiver channel also takes two fast loss-of-signal comparator flags, high and low, which are sampled on every clock.

Each channel has a six-bit status word, a six-bit fault-enable mask with the same bit layout, and a three-bit latch control. Alarms, warnings and comparator flags each have their own latch bit. A latched status bit holds until the host clears it through a per-bit clear strobe. The registered fault output goes high whenever any enabled status bit is set. Thresholds, masks and latch controls are held in a small register file that is written through an address and data port.

Top module: `thr_monitor`

## Requirements
- R1: After reset, every status bit and the fault output are 0. The temperature high thresholds reset to 7FFFh and its low thresholds to 8000h. The supply and receive-power high thresholds reset to FFFFh and their low thresholds to 0000h. All masks and latch controls reset to 0, so no reading can raise a bit before configuration.
- R2: Status bit 0 (alarm high) and bit 2 (warning high) of a channel are set on its update strobe when the reading is strictly greater than the matching threshold. An equal or lower reading writes 0 to a bit that is not latched.
- R3: Status bit 1 (alarm low) and bit 3 (warning low) are set on an update when the reading is strictly less than the matching threshold. An equal or higher reading writes 0 to a bit that is not latched.
- R4: Channel 0 compares its reading and thresholds as 16-bit two's complement values.
- R5: Channel 1 and the receive-power channels compare their readings and thresholds as unsigned 16-bit values.
- R6: Status bits 0 to 3 of a channel change only on that channel's own update strobe or on a clear. Changes to the reading bus or to the thresholds between strobes have no effect until the next strobe.
- R7: A latched bit stays at 1 until the clock edge at which its clear bit (clear bus bit channel*6+n) is 1. An update whose condition is true in that same cycle keeps the bit set.
- R8: Latch control bit 0 governs alarms, bit 1 governs warnings and bit 2 governs comparator flags. Each channel has its own latch control.
- R9: On receive-power channels, status bit 4 follows the high comparator flag and bit 5 follows the low flag, one cycle after the flag. When latch bit 2 is set, these bits hold until cleared. On channels 0 and 1, bits 4 and 5 are always 0.
- R10: The fault output goes to 1 one cycle after any status bit whose mask bit (same position) is 1 is set. It returns to 0 one cycle after no such bit remains. Masked bits have no effect on it.
- R11: The configuration address is channel*8 + field. The fields are 0 for alarm high, 1 for alarm low, 2 for warning high, 3 for warning low, 4 for mask (data bits 5:0) and 5 for latch control (data bits 2:0). A write changes only the addressed channel and takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | NRX+2 | Per-channel update strobe |
| meas_i | input | 16*(NRX+2) | Readings, channel c in bits c*16 +: 16 |
| qt_hi_i | input | NRX | Fast high comparator flag per receiver |
| qt_lo_i | input | NRX | Fast low comparator flag per receiver |
| clr_i | input | 6*(NRX+2) | Per-bit status clear strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | clog2(NRX+2)+3 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| stat_o | output | 6*(NRX+2) | Status words, channel c in bits c*6 +: 6 |
| fault_o | output | 1 | Registered fault interrupt |

## Verification
A reading strobed in one cycle shows in the status word right after the next rising edge. A comparator flag shows one edge after it is applied. The fault output follows the status by one more edge, and a configuration write acts from the edge that captures it. The bench drives every input on the falling edge and samples status at the falling edge after the capturing rising edge. It looks at the fault output one falling edge later, and checks both the cycle before that and the cycle itself. Threshold behaviour is swept value by value across each boundary on every channel type, with the expected bits computed arithmetically.

// File: rtl/thr_monitor_pkg.sv
package thr_monitor_pkg;
  localparam int MEAS_W = 16;
  localparam int SW     = 6;

  // status / mask bit positions
  localparam int B_AHI = 0;
  localparam int B_ALO = 1;
  localparam int B_WHI = 2;
  localparam int B_WLO = 3;
  localparam int B_QHI = 4;
  localparam int B_QLO = 5;

  // latch control bit positions
  localparam int L_ALM = 0;
  localparam int L_WRN = 1;
  localparam int L_QT  = 2;

  // configuration field codes
  localparam logic [2:0] F_AHI = 3'd0;
  localparam logic [2:0] F_ALO = 3'd1;
  localparam logic [2:0] F_WHI = 3'd2;
  localparam logic [2:0] F_WLO = 3'd3;
  localparam logic [2:0] F_EN  = 3'd4;
  localparam logic [2:0] F_LAT = 3'd5;

  typedef struct packed {
    logic [MEAS_W-1:0] ahi;
    logic [MEAS_W-1:0] alo;
    logic [MEAS_W-1:0] whi;
    logic [MEAS_W-1:0] wlo;
  } thr_set_t;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_monitor_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [MEAS_W-1:0]        wdata,
  output thr_set_t [NCH-1:0]       thr_o,
  output logic [NCH-1:0][SW-1:0]   en_o,
  output logic [NCH-1:0][2:0]      lat_o
);
  localparam int CW = AW - 3;
  localparam logic [MEAS_W-1:0] S_MAX = {1'b0, {(MEAS_W-1){1'b1}}};
  localparam logic [MEAS_W-1:0] S_MIN = {1'b1, {(MEAS_W-1){1'b0}}};
  localparam logic [MEAS_W-1:0] U_MAX = {MEAS_W{1'b1}};
  localparam logic [MEAS_W-1:0] U_MIN = {MEAS_W{1'b0}};

  logic [2:0] fld;
  assign fld = addr[2:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [MEAS_W-1:0] HI_RST = (c == 0) ? S_MAX : U_MAX;
    localparam logic [MEAS_W-1:0] LO_RST = (c == 0) ? S_MIN : U_MIN;

    logic          hit;
    thr_set_t      thr_q, thr_n;
    logic [SW-1:0] en_q, en_n;
    logic [2:0]    lat_q, lat_n;

    assign hit = we && (addr[AW-1:3] == CW'(c));

    always_comb begin
      thr_n = thr_q;
      en_n  = en_q;
      lat_n = lat_q;
      case (fld)
        F_AHI:   thr_n.ahi = wdata;
        F_ALO:   thr_n.alo = wdata;
        F_WHI:   thr_n.whi = wdata;
        F_WLO:   thr_n.wlo = wdata;
        F_EN:    en_n      = wdata[SW-1:0];
        F_LAT:   lat_n     = wdata[2:0];
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q.ahi <= HI_RST;
        thr_q.whi <= HI_RST;
        thr_q.alo <= LO_RST;
        thr_q.wlo <= LO_RST;
        en_q      <= '0;
        lat_q     <= '0;
      end else if (hit) begin
        thr_q <= thr_n;
        en_q  <= en_n;
        lat_q <= lat_n;
      end
    end

    assign thr_o[c] = thr_q;
    assign en_o[c]  = en_q;
    assign lat_o[c] = lat_q;
  end
endmodule

// File: rtl/thr_chan.sv
module thr_chan
  import thr_monitor_pkg::*;
#(
  parameter bit IS_SIGNED = 1'b0,
  parameter bit HAS_QT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [MEAS_W-1:0] meas,
  input  thr_set_t          thr,
  input  logic [2:0]        lat,
  input  logic              qt_hi,
  input  logic              qt_lo,
  input  logic [SW-1:0]     clr,
  output logic [SW-1:0]     stat
);
  logic gt_ahi, lt_alo, gt_whi, lt_wlo;

  if (IS_SIGNED) begin : g_signed
    assign gt_ahi = $signed(meas) > $signed(thr.ahi);
    assign lt_alo = $signed(meas) < $signed(thr.alo);
    assign gt_whi = $signed(meas) > $signed(thr.whi);
    assign lt_wlo = $signed(meas) < $signed(thr.wlo);
  end else begin : g_unsigned
    assign gt_ahi = meas > thr.ahi;
    assign lt_alo = meas < thr.alo;
    assign gt_whi = meas > thr.whi;
    assign lt_wlo = meas < thr.wlo;
  end

  logic [SW-1:0] cond, lat_bit, held, stat_q, stat_n;

  always_comb begin
    cond        = '0;
    cond[B_AHI] = gt_ahi;
    cond[B_ALO] = lt_alo;
    cond[B_WHI] = gt_whi;
    cond[B_WLO] = lt_wlo;
    cond[B_QHI] = HAS_QT && qt_hi;
    cond[B_QLO] = HAS_QT && qt_lo;
  end

  assign lat_bit = {{2{lat[L_QT]}}, {2{lat[L_WRN]}}, {2{lat[L_ALM]}}};
  assign held    = stat_q & ~clr;

  always_comb begin
    stat_n = held;
    for (int i = B_AHI; i <= B_WLO; i++) begin
      if (upd) stat_n[i] = lat_bit[i] ? (held[i] | cond[i]) : cond[i];
    end
    for (int i = B_QHI; i <= B_QLO; i++) begin
      stat_n[i] = lat_bit[i] ? (held[i] | cond[i]) : cond[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_n;
  end

  assign stat = stat_q;
endmodule

// File: rtl/thr_monitor.sv
module thr_monitor
  import thr_monitor_pkg::*;
#(
  parameter int NRX = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NRX+1:0]               upd_i,
  input  logic [(NRX+2)*MEAS_W-1:0]    meas_i,
  input  logic [NRX-1:0]               qt_hi_i,
  input  logic [NRX-1:0]               qt_lo_i,
  input  logic [(NRX+2)*SW-1:0]        clr_i,
  input  logic                         cfg_we_i,
  input  logic [$clog2(NRX+2)+2:0]     cfg_addr_i,
  input  logic [MEAS_W-1:0]            cfg_wdata_i,
  output logic [(NRX+2)*SW-1:0]        stat_o,
  output logic                         fault_o
);
  localparam int NCH = NRX + 2;
  localparam int AW  = $clog2(NCH) + 3;

  thr_set_t [NCH-1:0]     thr_q;
  logic [NCH-1:0][SW-1:0] en_q;
  logic [NCH-1:0][2:0]    lat_q;

  thr_cfg_regs #(.NCH(NCH), .AW(AW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we_i),
    .addr  (cfg_addr_i),
    .wdata (cfg_wdata_i),
    .thr_o (thr_q),
    .en_o  (en_q),
    .lat_o (lat_q)
  );

  logic [NCH-1:0] qh_ch, ql_ch;
  assign qh_ch = {qt_hi_i, 2'b00};
  assign ql_ch = {qt_lo_i, 2'b00};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    thr_chan #(.IS_SIGNED(c == 0), .HAS_QT(c >= 2)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (upd_i[c]),
      .meas  (meas_i[c*MEAS_W +: MEAS_W]),
      .thr   (thr_q[c]),
      .lat   (lat_q[c]),
      .qt_hi (qh_ch[c]),
      .qt_lo (ql_ch[c]),
      .clr   (clr_i[c*SW +: SW]),
      .stat  (stat_o[c*SW +: SW])
    );
  end

  logic [NCH*SW-1:0] en_flat;
  logic              fault_d, fault_q;
  assign en_flat = en_q;
  assign fault_d = |(stat_o & en_flat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/thr_monitor_chk.sv
module thr_monitor_chk
  import thr_monitor_pkg::*;
#(
  parameter int NRX = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NRX+1:0]               upd_i,
  input logic [(NRX+2)*MEAS_W-1:0]    meas_i,
  input logic [(NRX+2)*SW-1:0]        clr_i,
  input logic [(NRX+2)*SW-1:0]        stat_o,
  input logic                         fault_o,
  input thr_set_t [NRX+1:0]           thr_q,
  input logic [NRX+1:0][SW-1:0]       en_q,
  input logic [NRX+1:0][2:0]          lat_q
);
  localparam int NCH = NRX + 2;

  logic [NCH*SW-1:0] en_flat;
  assign en_flat = en_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (stat_o == '0 && !fault_o)); // R1

  AST_VCC_HI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i[1] && (meas_i[2*MEAS_W-1:MEAS_W] > thr_q[1].ahi)) |=> stat_o[SW+B_AHI]); // R2

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_i[c] && clr_i[c*SW +: 4] == 4'b0) |=> $stable(stat_o[c*SW +: 4])); // R6
  end

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[1][L_ALM] && stat_o[SW+B_AHI] && !clr_i[SW+B_AHI]) |=> stat_o[SW+B_AHI]); // R7

  AST_COMMON_NO_QT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[2*SW-1 -: 2] == 2'b00 && stat_o[SW-1 -: 2] == 2'b00); // R9

  AST_FAULT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_o & en_flat)) |=> fault_o); // R10

  AST_FAULT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_o & en_flat)) |=> !fault_o); // R10
endmodule

bind thr_monitor thr_monitor_chk #(.NRX(NRX)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .upd_i  (upd_i),
  .meas_i (meas_i),
  .clr_i  (clr_i),
  .stat_o (stat_o),
  .fault_o(fault_o),
  .thr_q  (thr_q),
  .en_q   (en_q),
  .lat_q  (lat_q)
);

// File: tb/tb_thr_monitor.sv
module tb_thr_monitor;
  localparam int CLK_P = 10;
  localparam int NRX   = 2;
  localparam int NCH   = NRX + 2;
  localparam int MW    = 16;
  localparam int SW    = 6;
  localparam int AW    = 5;

  logic              clk, rst_n;
  logic [NCH-1:0]    upd_i;
  logic [NCH*MW-1:0] meas_i;
  logic [NRX-1:0]    qt_hi_i, qt_lo_i;
  logic [NCH*SW-1:0] clr_i;
  logic              cfg_we_i;
  logic [AW-1:0]     cfg_addr_i;
  logic [MW-1:0]     cfg_wdata_i;
  logic [NCH*SW-1:0] stat_o;
  logic              fault_o;

  thr_monitor #(.NRX(NRX)) dut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .meas_i(meas_i),
    .qt_hi_i(qt_hi_i), .qt_lo_i(qt_lo_i), .clr_i(clr_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .stat_o(stat_o), .fault_o(fault_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] st(input int ch);
    return stat_o[ch*SW +: SW];
  endfunction

  function automatic logic [5:0] exp_bits(input int v, input int ah, input int al,
                                          input int wh, input int wl);
    return {2'b00, v < wl, v > wh, v < al, v > ah};
  endfunction

  task automatic wr(input int ch, input int fld, input logic [15:0] d);
    @(negedge clk);
    cfg_we_i    = 1'b1;
    cfg_addr_i  = AW'(ch*8 + fld);
    cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i    = 1'b0;
  endtask

  task automatic upd(input int ch, input logic [15:0] v);
    @(negedge clk);
    meas_i[ch*MW +: MW] = v;
    upd_i[ch] = 1'b1;
    @(negedge clk);
    upd_i = '0;
  endtask

  task automatic clr(input int bitpos);
    @(negedge clk);
    clr_i[bitpos] = 1'b1;
    @(negedge clk);
    clr_i = '0;
  endtask

  initial begin
    #(CLK_P*100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (every requirement) actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_i = '0; meas_i = '0; qt_hi_i = '0; qt_lo_i = '0;
    clr_i = '0; cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 status after reset", 32'(stat_o), 32'h0);
    check("R1 fault after reset", 32'(fault_o), 32'h0);

    // R1 default thresholds keep extremes quiet
    upd(0, 16'h7FFF); check("R1 temp max vs default", 32'(st(0)), 32'h0);
    upd(0, 16'h8000); check("R1 temp min vs default", 32'(st(0)), 32'h0);
    upd(1, 16'hFFFF); check("R1 vcc max vs default", 32'(st(1)), 32'h0);
    upd(1, 16'h0000); check("R1 vcc zero vs default", 32'(st(1)), 32'h0);
    upd(2, 16'hFFFF); check("R1 rx0 max vs default", 32'(st(2)), 32'h0);

    // supply sweep, unsigned
    wr(1, 0, 16'd1000); wr(1, 1, 16'd200); wr(1, 2, 16'd900); wr(1, 3, 16'd300);
    for (int v = 150; v <= 1050; v++) begin
      upd(1, v[15:0]);
      check("R2 R3 R5 vcc sweep", 32'(st(1)), 32'(exp_bits(v, 1000, 200, 900, 300)));
    end
    @(negedge clk);
    check("R10 masked bits keep fault low", 32'(fault_o), 32'h0);

    // temperature sweep, signed
    wr(0, 0, 16'd40); wr(0, 1, 16'hFFD8); wr(0, 2, 16'd30); wr(0, 3, 16'hFFE2);
    for (int v = -60; v <= 60; v++) begin
      upd(0, v[15:0]);
      check("R4 R2 R3 temp signed sweep", 32'(st(0)), 32'(exp_bits(v, 40, -40, 30, -30)));
    end

    // receive power sweep on rx1 across the sign bit
    wr(3, 0, 16'h9000); wr(3, 1, 16'h0100); wr(3, 2, 16'h8FF8); wr(3, 3, 16'h8000);
    for (int v = 32'h7FF0; v <= 32'h8010; v++) begin
      upd(3, v[15:0]);
      check("R5 rx unsigned low side", 32'(st(3)), 32'(exp_bits(v, 'h9000, 'h100, 'h8FF8, 'h8000)));
    end
    for (int v = 32'h8FF0; v <= 32'h9010; v++) begin
      upd(3, v[15:0]);
      check("R5 rx unsigned high side", 32'(st(3)), 32'(exp_bits(v, 'h9000, 'h100, 'h8FF8, 'h8000)));
    end

    // R6: only own strobe evaluates
    upd(1, 16'd1100);
    check("R6 vcc set", 32'(st(1)), 32'h05);
    @(negedge clk); meas_i[MW +: MW] = 16'd500;
    upd(3, 16'd5); upd(0, 16'd0);
    check("R6 vcc unchanged by other strobes", 32'(st(1)), 32'h05);
    wr(1, 0, 16'd2000);
    repeat (2) @(negedge clk);
    check("R6 vcc unchanged by threshold write", 32'(st(1)), 32'h05);
    upd(1, 16'd1100);
    check("R6 new threshold on next update", 32'(st(1)), 32'h04);
    wr(1, 0, 16'd1000);

    // R7 R8: latch alarms only on supply
    wr(1, 5, 16'h0001);
    upd(1, 16'd1100); check("R7 latched set", 32'(st(1)), 32'h05);
    upd(1, 16'd500);  check("R8 alarm held warn not", 32'(st(1)), 32'h01);
    upd(1, 16'd100);  check("R7 both alarms latched", 32'(st(1)), 32'h0B);
    clr(SW + 1);      check("R7 clear one bit only", 32'(st(1)), 32'h09);
    @(negedge clk);
    meas_i[MW +: MW] = 16'd1100; upd_i[1] = 1'b1; clr_i[SW] = 1'b1;
    @(negedge clk);
    upd_i = '0; clr_i = '0;
    check("R7 update wins over clear", 32'(st(1)), 32'h05);
    @(negedge clk);
    meas_i[MW +: MW] = 16'd500; upd_i[1] = 1'b1; clr_i[SW] = 1'b1;
    @(negedge clk);
    upd_i = '0; clr_i = '0;
    check("R7 clear with false condition", 32'(st(1)), 32'h00);
    wr(1, 5, 16'h0000);

    // R9 comparator flags
    @(negedge clk); qt_hi_i[0] = 1'b1;
    @(negedge clk); check("R9 flag high seen", 32'(st(2)), 32'h10);
    qt_hi_i[0] = 1'b0;
    @(negedge clk); check("R9 flag not latched drops", 32'(st(2)), 32'h00);
    wr(2, 5, 16'h0004); wr(3, 5, 16'h0000);
    @(negedge clk); qt_lo_i = 2'b11;
    @(negedge clk); qt_lo_i = 2'b00;
    @(negedge clk);
    check("R8 R9 rx0 flag latched", 32'(st(2)), 32'h20);
    check("R8 R9 rx1 flag not latched", 32'(st(3)) & 32'h30, 32'h00);
    clr(2*SW + 5);
    check("R9 latched flag cleared", 32'(st(2)), 32'h00);
    wr(2, 5, 16'h0000);

    // R10 fault path
    wr(2, 4, 16'h0010);
    @(negedge clk); qt_hi_i[0] = 1'b1;
    @(negedge clk); check("R10 fault one cycle after status", 32'(fault_o), 32'h0);
    @(negedge clk); check("R10 fault rises", 32'(fault_o), 32'h1);
    qt_hi_i[0] = 1'b0;
    @(negedge clk); check("R10 fault held while status set", 32'(fault_o), 32'h1);
    @(negedge clk); check("R10 fault falls", 32'(fault_o), 32'h0);
    upd(1, 16'd950);
    check("R10 vcc warn set", 32'(st(1)), 32'h04);
    wr(1, 4, 16'h0004);
    check("R10 fault waits for mask register", 32'(fault_o), 32'h0);
    @(negedge clk); check("R10 fault by same-layout mask", 32'(fault_o), 32'h1);
    wr(1, 4, 16'h0001);
    @(negedge clk); check("R10 other mask bit ignores warn", 32'(fault_o), 32'h0);

    // R11 address map isolation
    wr(2, 0, 16'd100);
    upd(3, 16'd150); check("R11 rx1 untouched by rx0 write", 32'(st(3)) & 32'h01, 32'h0);
    upd(2, 16'd150); check("R11 rx0 threshold applied", 32'(st(2)), 32'h01);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule